// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Corrector

This block decides whether one 512-byte NAND data unit read from flash needs correcting, and which bit to correct. It takes the 3-byte check code stored in the spare area and the 32-bit raw parity word that an upstream parity generator accumulated over the data. It packs the raw word into a 3-byte computed code, XORs the two codes, counts the differing bits and classifies the unit as clean, corrected or uncorrectable. For a correctable error it reports a 9-bit byte offset and a 3-bit bit index inside that byte.

A software or DMA sequencer presents both codes and pulses `start`. When `done` pulses, it reads the status and location. It can then stream the addressed data byte through the combinational fix port to repair it. Identical codes settle in one cycle, and all other cases settle in three. Control and status are plain pins. No stream runs through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: The computed code is packed from the raw word as {raw[27:24], raw[11:8], raw[23:16], raw[7:0]} (code bit 23 down to 0). Code bits [7:0], [15:8] and [23:16] are the low, middle and high code bytes, and the stored code uses the same layout.
- R2: When the stored and computed codes are identical, `done` pulses in the first cycle after the accepted `start` and status is clean (2'b00).
- R3: The difference d = stored ^ computed is reordered into e with e[5:0]=d[23:18], e[13:6]=d[7:0], e[21:14]=d[15:8] and e[23:22]=d[17:16]. Pair k is (e[2k], e[2k+1]). When exactly 12 bits of d are set, status is corrected (2'b01). In that case byte_off = {e[23],e[21],...,e[7]} and bit_idx = {e[5],e[3],e[1]}.
- R4: When exactly one bit of d is set, status is uncorrectable (2'b10).
- R5: Any other nonzero count gives uncorrectable status, except in the case covered by R6.
- R6: A stored code of 24'hFFFFFF together with a computed code of zero is an erased unit and reports clean.
- R7: For nonzero d, `done` pulses in the third cycle after the accepted `start`. `done` is a single-cycle pulse.
- R8: status, byte_off and bit_idx change only when `done` pulses and hold between results. byte_off and bit_idx read zero unless status is corrected.
- R9: fix_out = fix_in ^ (1 << bit_idx) while status is corrected, and fix_out = fix_in otherwise.
- R10: A `start` that arrives while a nonzero-difference check is still in flight is ignored.
- R11: After reset, done is 0, status is clean, and byte_off and bit_idx are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check of the presented codes |
| stored_code | input | 24 | Check code read from the spare area |
| raw_parity | input | 32 | Raw parity word from the parity generator |
| done | output | 1 | One-cycle result pulse |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| byte_off | output | 9 | Byte offset of the bad bit within the unit |
| bit_idx | output | 3 | Bit index of the bad bit within the byte |
| fix_in | input | 8 | Data byte to repair |
| fix_out | output | 8 | Repaired data byte |

## Verification
The in-RTL assertions check, on every cycle, the things that hold from one cycle to the next: the single-cycle latency for equal codes, the progress of the pipeline, the one-bit flip or pass-through at the fix port, the zeroed location outside the corrected status, and that results never change without `done`. Only the bench scenarios can show that the packing, the pair ordering and the classification are correct. To do that, the bench sweeps all 4096 byte/bit error locations, every single-bit fault in the stored code, erased and near-erased units, and a start issued while a check is busy, and compares each result against values it computes itself.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int RAW_W   = 32;
  localparam int CODE_W  = 24;
  localparam int PAIRS   = CODE_W / 2;
  localparam int BIT_W   = 3;
  localparam int OFF_W   = PAIRS - BIT_W;
  localparam int CNT_W   = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIXED   = 2'b01,
    ST_UNFIX   = 2'b10
  } fix_status_t;
endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
  import ecc_fix_pkg::*;
(
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);
  logic unused_raw_bits;
  assign unused_raw_bits = ^{raw[31:28], raw[15:12]};
  // high byte carries two nibbles; the upper one comes from raw[27:24]
  assign code = {raw[27:24], raw[11:8], raw[23:16], raw[7:0]};
endmodule

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int W    = 24,
  parameter int LANE = 6
) (
  input  logic [W-1:0]           vec,
  output logic [$clog2(W+1)-1:0] cnt
);
  localparam int CW = $clog2(W + 1);
  localparam int NL = (W + LANE - 1) / LANE;

  logic [CW-1:0] lane_cnt [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    always_comb begin
      lane_cnt[l] = '0;
      for (int i = 0; i < LANE; i++) begin
        if (l * LANE + i < W) lane_cnt[l] = lane_cnt[l] + CW'(vec[l * LANE + i]);
      end
    end
  end

  always_comb begin
    cnt = '0;
    for (int l = 0; l < NL; l++) cnt = cnt + lane_cnt[l];
  end
endmodule

// File: rtl/ecc_locator.sv
module ecc_locator
  import ecc_fix_pkg::*;
(
  input  logic [CODE_W-1:0] diff,
  input  logic [CNT_W-1:0]  ones,
  input  logic              erased,
  output fix_status_t       status,
  output logic [OFF_W-1:0]  off,
  output logic [BIT_W-1:0]  bidx
);
  logic [CODE_W-1:0] e;
  logic [PAIRS-1:0]  odd_m;

  // reorder the difference into pair order: (e[2k], e[2k+1]) is pair k
  assign e = {diff[17:16], diff[15:8], diff[7:0], diff[23:18]};

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign odd_m[k] = e[2 * k + 1];
  end

  always_comb begin
    status = ST_UNFIX;
    off    = '0;
    bidx   = '0;
    if (ones == CNT_W'(0)) begin
      status = ST_CLEAN;
    end else if (ones == CNT_W'(PAIRS)) begin
      status = ST_FIXED;
      bidx   = odd_m[BIT_W-1:0];
      off    = odd_m[PAIRS-1:BIT_W];
    end else if (ones == CNT_W'(1)) begin
      status = ST_UNFIX;
    end else if (erased) begin
      status = ST_CLEAN;
    end
  end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import ecc_fix_pkg::*;
#(
  parameter int POP_LANE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [RAW_W-1:0]  raw_parity,
  output logic              done,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  byte_off,
  output logic [BIT_W-1:0]  bit_idx,
  input  logic [7:0]        fix_in,
  output logic [7:0]        fix_out
);
  logic [CODE_W-1:0] calc_code, diff_in;
  logic              busy, accept;

  ecc_code_pack u_pack (.raw(raw_parity), .code(calc_code));

  assign diff_in = stored_code ^ calc_code;
  assign busy    = s1_vld | s2_vld;
  assign accept  = start & ~busy;

  // stage 1: capture the difference and the erased flag
  logic              s1_vld, s1_erased;
  logic [CODE_W-1:0] s1_diff;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_erased <= 1'b0;
      s1_diff   <= '0;
    end else begin
      s1_vld <= accept && (diff_in != '0);
      if (accept) begin
        s1_diff   <= diff_in;
        s1_erased <= (stored_code == {CODE_W{1'b1}}) && (calc_code == '0);
      end
    end
  end

  // stage 2: register the count of differing bits
  logic [CNT_W-1:0]  ones_c, s2_ones;
  logic              s2_vld, s2_erased;
  logic [CODE_W-1:0] s2_diff;

  ecc_popcount #(.W(CODE_W), .LANE(POP_LANE)) u_pop (.vec(s1_diff), .cnt(ones_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld    <= 1'b0;
      s2_ones   <= '0;
      s2_diff   <= '0;
      s2_erased <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_ones   <= ones_c;
        s2_diff   <= s1_diff;
        s2_erased <= s1_erased;
      end
    end
  end

  // stage 3: classify and publish
  fix_status_t      cls_st;
  logic [OFF_W-1:0] cls_off;
  logic [BIT_W-1:0] cls_bit;

  ecc_locator u_loc (
    .diff(s2_diff), .ones(s2_ones), .erased(s2_erased),
    .status(cls_st), .off(cls_off), .bidx(cls_bit)
  );

  fix_status_t st_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      st_q     <= ST_CLEAN;
      byte_off <= '0;
      bit_idx  <= '0;
    end else begin
      done <= 1'b0;
      if (s2_vld) begin
        done     <= 1'b1;
        st_q     <= cls_st;
        byte_off <= cls_off;
        bit_idx  <= cls_bit;
      end else if (accept && (diff_in == '0)) begin
        done     <= 1'b1;
        st_q     <= ST_CLEAN;
        byte_off <= '0;
        bit_idx  <= '0;
      end
    end
  end

  assign status  = st_q;
  assign fix_out = (st_q == ST_FIXED) ? (fix_in ^ (8'd1 << bit_idx)) : fix_in;

  // R2: identical codes finish in one cycle, clean
  a_r2_equal_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && stored_code == calc_code) |=> (done && status == 2'b00));
  // R7: pipeline advances one stage per cycle
  a_r7_pipe_step: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> (s2_vld && !s1_vld));
  a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(s2_vld) || $past(start)));
  // R8: results change only with done, location zero unless corrected
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(status) && $stable(byte_off) && $stable(bit_idx)));
  a_r8_zero_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b01) |-> (byte_off == '0 && bit_idx == '0));
  // R9: fix port flips exactly one bit only when corrected
  a_r9_flip_one: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01) |-> ($countones(fix_out ^ fix_in) == 1));
  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b01) |-> (fix_out == fix_in));
  // R10: no new check enters while one is in flight
  a_r10_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> !($past(s1_vld) && $past(s2_vld)));
endmodule

// File: tb/ecc_syndrome_fix_tb.sv
module ecc_syndrome_fix_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [31:0] raw_parity = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byte_off;
  logic [2:0]  bit_idx;
  logic [7:0]  fix_in = '0;
  logic [7:0]  fix_out;

  int tests = 0;
  int fails = 0;
  int lat;

  always #5 clk = ~clk;

  ecc_syndrome_fix u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
    .raw_parity(raw_parity), .done(done), .status(status), .byte_off(byte_off),
    .bit_idx(bit_idx), .fix_in(fix_in), .fix_out(fix_out)
  );

  function automatic logic [23:0] pack(input logic [31:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  // build a 12-bit difference whose odd pair members spell {off,bit}
  function automatic logic [23:0] loc_diff(input int off, input int b);
    logic [11:0] loc;
    logic [23:0] e;
    loc = {off[8:0], b[2:0]};
    for (int k = 0; k < 12; k++) begin
      e[2*k+1] = loc[k];
      e[2*k]   = ~loc[k];
    end
    return {e[5:0], e[23:22], e[21:14], e[13:6]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] sc, input logic [31:0] rp);
    @(negedge clk);
    stored_code = sc;
    raw_parity  = rp;
    start       = 1'b1;
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rp;
    logic [1:0]  st_prev;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 status", status, 0);
    chk("R11 loc", {byte_off, bit_idx}, 0);
    rst_n = 1'b1;

    // R1 R2 equal codes, several raw words incl. ignored nibbles
    for (int i = 0; i < 16; i++) begin
      rp = 32'h9E37_79B9 * (i + 1);
      run(pack(rp), rp);
      chk("R2 latency", lat, 1);
      chk("R1 R2 clean", status, 2'b00);
    end

    // R3 R7 R9: every byte/bit location
    for (int off = 0; off < 512; off++) begin
      for (int b = 0; b < 8; b++) begin
        rp = 32'h1234_5678 ^ (off * 32'h0001_0203) ^ b;
        run(pack(rp) ^ loc_diff(off, b), rp);
        chk("R7 latency", lat, 3);
        chk("R3 status", status, 2'b01);
        chk("R3 location", {byte_off, bit_idx}, {off[8:0], b[2:0]});
        fix_in = 8'(off) ^ 8'hA5;
        #1;
        chk("R9 flip", fix_out, fix_in ^ (8'd1 << b));
      end
    end
    @(negedge clk);
    chk("R7 pulse", done, 0);

    // R8 hold while idle
    st_prev = status;
    repeat (3) @(negedge clk);
    chk("R8 hold", {status, byte_off, bit_idx}, {st_prev, 9'd511, 3'd7});

    // R4 single stored-code bit fault
    for (int i = 0; i < 24; i++) begin
      rp = 32'hC0DE_F00D + i;
      run(pack(rp) ^ (24'd1 << i), rp);
      chk("R4 status", status, 2'b10);
      chk("R8 zero loc", {byte_off, bit_idx}, 0);
      fix_in = 8'h3C;
      #1;
      chk("R9 pass", fix_out, 8'h3C);
    end

    // R5 other counts
    for (int n = 2; n <= 24; n++) begin
      if (n == 12) continue;
      rp = 32'h0F0F_3C3C;
      run(pack(rp) ^ ((24'd1 << n) - 24'd1), rp);
      chk("R5 status", status, 2'b10);
    end

    // R6 erased unit: raw bits outside the code are don't-care
    run(24'hFFFFFF, 32'hF000_F000);
    chk("R6 erased", status, 2'b00);
    chk("R6 latency", lat, 3);
    run(24'hFFFFFF, 32'h0000_0001);
    chk("R5 near erased", status, 2'b10);
    run(24'hFFFFFE, 32'h0);
    chk("R5 near erased stored", status, 2'b10);

    // R10 start while busy is ignored
    rp = 32'h5555_AAAA;
    @(negedge clk);
    stored_code = pack(rp) ^ loc_diff(300, 5);
    raw_parity = rp;
    start = 1'b1;
    @(negedge clk);
    stored_code = pack(rp);
    @(negedge clk);
    start = 1'b0;
    chk("R10 no early done", done, 0);
    @(negedge clk);
    chk("R10 done", done, 1);
    chk("R10 first result", {status, byte_off, bit_idx}, {2'b01, 9'd300, 3'd5});
    @(negedge clk);
    chk("R10 single done", done, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule